// File: doc/BRIEF.md
# I2C Bus Clear Recovery Sequencer

This block frees an I2C bus that a stuck target device holds low. After a start request it watches the sampled SDA and SCL lines. If both lines read high before a timeout expires, the bus is free and the block reports done at once. If the bus stays busy for the whole timeout, the block runs a recovery attempt:

- It leaves SDA released, so the target sees a not-acknowledge.
- It clocks SCL nine times.
- It closes with a STOP condition.

If the lines still do not read high after the STOP, the attempt has failed. The block waits out a short reinitialisation gap and watches the bus again. Once the attempt limit is used up it raises fail.

Both bus lines are driven through open-drain enables: an enable of 1 pulls the line low and 0 releases it. Every phase of the sequence lasts a programmable half-period, counted in system clocks and captured when the request is accepted. The done and fail levels stay asserted until the next request.

Top module: `i2c_bus_clear`

## Requirements
- R1: While reset is asserted and right after it, scl_oe_o, sda_oe_o, busy_o, done_o and fail_o are all 0.
- R2: A start_i pulse taken while idle, done or failed begins a bus watch. If sda_i and scl_i both read 1 on the first clock edge of the watch, done_o rises one cycle after the accepting edge and no SCL pulse is driven.
- R3: If the bus stays busy for TIMEOUT_CYC cycles of watching, an attempt begins. It opens with one half-period in which both enables are 0 (not-acknowledge), placed before the first SCL low.
- R4: Each attempt drives exactly 9 clock pulses on SCL. Each pulse is scl_oe_o=1 (low) for H cycles, then scl_oe_o=0 for H cycles. H is half_period_i, and a value of 0 counts as 1.
- R5: The STOP is built in four phases of H cycles each: SCL low; SCL low and SDA low; SCL released while SDA stays low; both released. sda_oe_o therefore rises only while SCL is already held low, and falls only while SCL is already released.
- R6: One cycle after the STOP, done_o rises if sda_i and scl_i both read 1. Otherwise the attempt counts as failed.
- R7: A failed attempt is followed by H released cycles and a new watch of TIMEOUT_CYC cycles. When MAX_TRIES (default 2) attempts have failed, fail_o rises instead. One attempt takes TIMEOUT_CYC + 23·H + 1 cycles.
- R8: start_i is ignored while busy_o is 1.
- R9: busy_o is 1 from the cycle after acceptance until done_o or fail_o rises. done_o and fail_o then hold, with busy_o at 0, until the next accepted start.
- R10: The half-period is captured on acceptance. Changing half_period_i during a run changes no phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to check and, if needed, clear the bus |
| sda_i | input | 1 | Sampled SDA line level |
| scl_i | input | 1 | Sampled SCL line level |
| half_period_i | input | HP_W | Phase length in system clocks (0 treated as 1) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Bus found free; held until next start |
| fail_o | output | 1 | Attempt limit reached with the bus still held |

## Verification
The hardest situation to reach from the ports is a run in which the first attempt fails and the second succeeds. It needs a target that keeps SDA low through the whole first pulse train and STOP, then lets go in the middle of the second train. The bench models the open-drain bus together with a target that counts rising SCL edges on the wired line and releases SDA after a chosen count. A count of 15 forces exactly this two-attempt path, and a count of 10 makes the release land inside the STOP. Separate runs with SCL itself stuck low, and with a mid-run start pulse carrying a new half-period, reach the failure limit and the ignored-input cases.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_NACK,
    ST_LOW,
    ST_HIGH,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C,
    ST_STOP_D,
    ST_CHECK,
    ST_REINIT,
    ST_DONE,
    ST_FAIL
  } rec_state_e;

  // States whose length is one captured half-period
  function automatic logic is_timed(input rec_state_e s);
    return (s == ST_NACK)   || (s == ST_LOW)    || (s == ST_HIGH)   ||
           (s == ST_STOP_A) || (s == ST_STOP_B) || (s == ST_STOP_C) ||
           (s == ST_STOP_D) || (s == ST_REINIT);
  endfunction

  // States that can accept a new request
  function automatic logic is_rest(input rec_state_e s);
    return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL);
  endfunction

endpackage

// File: rtl/i2cr_span_counter.sv
module i2cr_span_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         at_end
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end

  assign at_end = en && (cnt == limit - 1'b1);

  // R4: a running span never passes its limit before the owner moves on
  p_span_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (cnt < limit));

endmodule

// File: rtl/i2cr_tally.sv
module i2cr_tally #(
  parameter int W   = 4,
  parameter int CAP = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (inc)  count <= count + 1'b1;
  end

  // R4 for the pulse tally, R7 for the attempt tally
  p_tally_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= W'(CAP));

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2cr_pkg::*;
#(
  parameter int HP_W        = 8,
  parameter int TIMEOUT_CYC = 64,
  parameter int MAX_TRIES   = 2,
  parameter int PULSES      = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            sda_i,
  input  logic            scl_i,
  input  logic [HP_W-1:0] half_period_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o
);

  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int PC_W = $clog2(PULSES + 1);
  localparam int AC_W = $clog2(MAX_TRIES + 1);

  function automatic logic [HP_W-1:0] eff_half(input logic [HP_W-1:0] hp);
    return (hp == '0) ? HP_W'(1) : hp;
  endfunction

  rec_state_e state_q, state_d;
  logic [HP_W-1:0] h_q;
  logic [PC_W-1:0] pulse_cnt;
  logic [AC_W-1:0] attempt_cnt;

  // named events
  logic accept_ev, bus_idle, ph_end, wait_end, pulse_done_ev, attempt_fail_ev;
  logic last_pulse, last_attempt;

  assign bus_idle        = sda_i && scl_i;
  assign accept_ev       = start_i && is_rest(state_q);
  assign pulse_done_ev   = (state_q == ST_HIGH) && ph_end;
  assign attempt_fail_ev = (state_q == ST_CHECK) && !bus_idle;
  assign last_pulse      = (pulse_cnt == PC_W'(PULSES - 1));
  assign last_attempt    = (attempt_cnt == AC_W'(MAX_TRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      h_q     <= HP_W'(1);
    end else begin
      state_q <= state_d;
      if (accept_ev) h_q <= eff_half(half_period_i);
    end
  end

  i2cr_span_counter #(.W(HP_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_d != state_q),
    .en     (is_timed(state_q)),
    .limit  (h_q),
    .at_end (ph_end)
  );

  i2cr_span_counter #(.W(TO_W)) u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q != ST_WAIT),
    .en     (state_q == ST_WAIT),
    .limit  (TO_W'(TIMEOUT_CYC)),
    .at_end (wait_end)
  );

  i2cr_tally #(.W(PC_W), .CAP(PULSES)) u_pulses (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_NACK),
    .inc   (pulse_done_ev),
    .count (pulse_cnt)
  );

  i2cr_tally #(.W(AC_W), .CAP(MAX_TRIES)) u_attempts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_ev),
    .inc   (attempt_fail_ev),
    .count (attempt_cnt)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (bus_idle)      state_d = ST_DONE;
        else if (wait_end) state_d = ST_NACK;
      end
      ST_NACK:   if (ph_end) state_d = ST_LOW;
      ST_LOW:    if (ph_end) state_d = ST_HIGH;
      ST_HIGH:   if (ph_end) state_d = last_pulse ? ST_STOP_A : ST_LOW;
      ST_STOP_A: if (ph_end) state_d = ST_STOP_B;
      ST_STOP_B: if (ph_end) state_d = ST_STOP_C;
      ST_STOP_C: if (ph_end) state_d = ST_STOP_D;
      ST_STOP_D: if (ph_end) state_d = ST_CHECK;
      ST_CHECK: begin
        if (bus_idle)          state_d = ST_DONE;
        else if (last_attempt) state_d = ST_FAIL;
        else                   state_d = ST_REINIT;
      end
      ST_REINIT: if (ph_end) state_d = ST_WAIT;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign scl_oe_o = (state_q == ST_LOW)    || (state_q == ST_STOP_A) || (state_q == ST_STOP_B);
  assign sda_oe_o = (state_q == ST_STOP_B) || (state_q == ST_STOP_C);
  assign busy_o   = !is_rest(state_q);
  assign done_o   = (state_q == ST_DONE);
  assign fail_o   = (state_q == ST_FAIL);

  // R3: SDA is released in the cycle before the first clock low of an attempt
  p_nack_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe_o) && pulse_cnt == '0) |-> $past(!sda_oe_o));

  // R5: SDA only goes low under an already-low SCL
  p_sda_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> (scl_oe_o && $past(scl_oe_o)));

  // R5: SDA only releases under an already-released SCL (STOP)
  p_stop_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> (!scl_oe_o && $past(!scl_oe_o)));

  // R6: done only follows a cycle in which both lines read high
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(sda_i && scl_i));

  // R7: failure only after the attempt limit is used up
  p_fail_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (attempt_cnt == AC_W'(MAX_TRIES)));

  // R9: an accepted request makes the block busy on the next cycle
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

endmodule

// File: tb/i2c_bus_clear_tb_top.sv
module i2c_bus_clear_tb_top;

  localparam int TMO   = 40;
  localparam int NPULS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] half_period_i = 8'd1;
  logic scl_oe, sda_oe, busy_o, done_o, fail_o;
  logic scl_bus, sda_bus;

  bit sda_hold = 1'b0;
  bit scl_hold = 1'b0;
  int rel_edges = 0;
  int edge_cnt = 0;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int start_cyc = 0;
  int cur_h = 1;
  int mon_pulses = 0;
  int low_run = 0;
  int sda_run = 0;
  bit scl_prev = 1'b0, sda_prev = 1'b0, done_prev = 1'b0, fail_prev = 1'b0;

  typedef struct {
    bit    exp_done;
    int    exp_pulses;
    int    exp_lat;
    string tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_bus = !scl_oe && !scl_hold;
  assign sda_bus = !sda_oe && !sda_hold;

  i2c_bus_clear #(.HP_W(8), .TIMEOUT_CYC(TMO), .MAX_TRIES(2), .PULSES(NPULS)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .sda_i         (sda_bus),
    .scl_i         (scl_bus),
    .half_period_i (half_period_i),
    .scl_oe_o      (scl_oe),
    .sda_oe_o      (sda_oe),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fail_o        (fail_o)
  );

  // target device model: lets SDA go after a number of rising SCL edges
  always @(posedge scl_bus) begin
    edge_cnt++;
    if (sda_hold && rel_edges > 0 && edge_cnt >= rel_edges) sda_hold = 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int h);
    return (h < 1) ? 1 : h;
  endfunction

  // cycles: watch + not-ack + nine pulses + four stop phases + check
  function automatic int span(input int tries, input int h);
    int one;
    one = TMO + h + 2 * NPULS * h + 4 * h + 1;
    return tries * one + (tries - 1) * h;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe && !scl_prev) begin
        mon_pulses++;
        low_run = 1;
      end else if (scl_oe) begin
        low_run++;
      end else if (scl_prev) begin
        if (mon_pulses % (NPULS + 1) == 0)
          check(low_run == 2 * cur_h, "R5 stop scl low span", low_run, 2 * cur_h);
        else
          check(low_run == cur_h, "R4 scl low span", low_run, cur_h);
      end
      if (sda_oe) sda_run++;
      else if (sda_prev) begin
        check(sda_run == 2 * cur_h, "R5 sda low span", sda_run, 2 * cur_h);
        sda_run = 0;
      end
      if ((done_o && !done_prev) || (fail_o && !fail_prev)) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", 1, 0);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check(done_o == it.exp_done, {"R6/R7 outcome ", it.tag}, int'(done_o), int'(it.exp_done));
          check(mon_pulses == it.exp_pulses, {"R4 pulse count ", it.tag}, mon_pulses, it.exp_pulses);
          if (it.exp_lat >= 0)
            check((cyc - start_cyc) == it.exp_lat, {"R7 latency ", it.tag}, cyc - start_cyc, it.exp_lat);
        end
      end
    end
    scl_prev  = scl_oe;
    sda_prev  = sda_oe;
    done_prev = done_o;
    fail_prev = fail_o;
  end

  task automatic run_case(input string tag, input int h, input bit sda_h, input bit scl_h,
                          input int rel_e, input int rel_c, input bit exp_d,
                          input int exp_p, input int exp_l, input bit poke);
    exp_item_t it;
    @(posedge clk); #2;
    half_period_i = 8'(h);
    cur_h      = eff(h);
    sda_hold   = sda_h;
    scl_hold   = scl_h;
    rel_edges  = rel_e;
    edge_cnt   = 0;
    mon_pulses = 0;
    sda_run    = 0;
    it.exp_done = exp_d; it.exp_pulses = exp_p; it.exp_lat = exp_l; it.tag = tag;
    sb_q.push_back(it);
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    start_cyc = cyc;
    if (exp_l != 1) begin
      @(posedge clk); #2;
      check(busy_o == 1'b1, {"R9 busy during run ", tag}, int'(busy_o), 1);
    end
    if (rel_c > 0) begin
      repeat (rel_c - 2) @(posedge clk);
      #2 sda_hold = 1'b0;
    end
    if (poke) begin
      // R8 and R10: a start pulse and a new half-period mid-run must change nothing
      repeat (30) @(posedge clk);
      #2 start_i = 1'b1; half_period_i = 8'd7;
      @(posedge clk); #2 start_i = 1'b0;
    end
    while (!(done_o || fail_o)) begin
      @(posedge clk); #2;
    end
    repeat (4) @(posedge clk);
    #2;
    check(done_o == exp_d && fail_o == !exp_d, {"R9 result held ", tag},
          int'({done_o, fail_o}), int'({exp_d, !exp_d}));
    check(busy_o == 1'b0, {"R9 not busy after end ", tag}, int'(busy_o), 0);
    sda_hold = 1'b0;
    scl_hold = 1'b0;
    rel_edges = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({scl_oe, sda_oe, busy_o, done_o, fail_o} == 5'b0, "R1 outputs in reset",
          int'({scl_oe, sda_oe, busy_o, done_o, fail_o}), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check({scl_oe, sda_oe, busy_o, done_o, fail_o} == 5'b0, "R1 outputs after reset",
          int'({scl_oe, sda_oe, busy_o, done_o, fail_o}), 0);

    // R2: free bus, done on the first watch edge
    run_case("R2 free bus", 3, 1'b0, 1'b0, 0, 0, 1'b1, 0, 1, 1'b0);
    // R2: bus frees itself during the watch
    run_case("R2 release in watch", 2, 1'b1, 1'b0, 0, 10, 1'b1, 0, 10, 1'b0);
    // R3 R4 R5 R6: one attempt clears a target that lets go after 3 edges
    run_case("R6 one attempt", 2, 1'b1, 1'b0, 3, 0, 1'b1, 10, span(1, 2), 1'b0);
    // R5 R6: release lands inside the STOP
    run_case("R5 release at stop", 3, 1'b1, 1'b0, 10, 0, 1'b1, 10, span(1, 3), 1'b0);
    // R7: first attempt fails, second clears
    run_case("R7 second attempt", 1, 1'b1, 1'b0, 15, 0, 1'b1, 20, span(2, 1), 1'b0);
    // R7: SDA stuck for good
    run_case("R7 sda stuck", 4, 1'b1, 1'b0, 0, 0, 1'b0, 20, span(2, 4), 1'b0);
    // R4 R7: SCL stuck, half-period 0 behaves as 1
    run_case("R4 scl stuck h0", 0, 1'b0, 1'b1, 0, 0, 1'b0, 20, span(2, 1), 1'b0);
    // R8 R10: mid-run start and half-period change ignored
    run_case("R8 R10 ignored inputs", 2, 1'b1, 1'b0, 3, 0, 1'b1, 10, span(1, 2), 1'b1);

    check(sb_q.size() == 0, "R9 all results seen", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule